// File: doc/BRIEF.md
# Phase-locked 1x/2x clock transfer bridge

This block moves data words between two clock domains that come from one source. The fast clock runs at exactly twice the slow rate. The bridge does not use multi-flop synchronizers. It rebuilds, inside the fast domain, a phase enable that marks one fast edge per slow period: the fast edge that lands midway between two slow rising edges. Every fast-domain register that takes slow-domain data, or that the slow domain reads, changes state only on that marked edge. As a result, neither domain ever samples a value that the other domain changes on a coincident edge, and clock-net skew of about a nanosecond in either direction does no harm.

A parameter picks how the phase indicator is formed:
- the **replica** style samples the slow clock itself;
- the **toggle** style XORs a bit that flips on each slow rising edge with a copy of that bit taken on the slow falling edge.

In both styles the indicator is retimed by a fast-clock flop on the falling fast edge. That edge lies a quarter slow period away from every slow transition, so both styles give the same enable. After reset the enable is held off for a settling window of slow periods.

Forward words enter with a valid flag in the slow domain and leave in the fast domain as a one-fast-cycle pulse. Results from the fast domain go back through an enable-qualified holding register and reappear in the slow domain as a one-slow-cycle pulse.

Top module: `phase_bridge`

## Requirements
- R1: While `rst` is high, every data and valid output clears to zero. This covers `f_data`, `f_valid`, `s_ret_data` and `s_ret_valid`, and both indicator flops.
- R2: Once settled, the internal phase enable is high on exactly one of every two fast rising edges. That edge is the one midway through the slow period, not the one aligned with a slow rising edge.
- R3: Each slow-domain word sampled with `s_valid` high appears on `f_data` exactly once, with `f_valid` high for one fast cycle, in the order presented. No word is lost or repeated, and a slow cycle with `s_valid` low produces no pulse.
- R4: The fast-domain capture registers (`f_data`, `f_valid`) change only on the enabled fast edge. When sampled on a falling fast edge, `f_valid` is therefore only ever high while `clk_slow` is low.
- R5: `f_ret_data`/`f_ret_valid` are sampled on the enabled fast edges. Each sampled valid result is presented once on `s_ret_data` with `s_ret_valid` high for one slow cycle, in order, with none lost.
- R6: The return holding register loads only on the enabled fast edge, so its value is stable across the following slow rising edge.
- R7: The replica style (`STYLE` = 0) and the toggle style (`STYLE` = 1) give identical outputs cycle for cycle once both have settled.
- R8: For the first `SETTLE_SLOW` (default 2) slow periods after `rst` falls, `f_valid` stays low even if `s_valid` is high.
- R9: R3 and R5 hold with the fast clock skewed against the slow clock by any amount up to ±1 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow clock (1x) |
| clk_fast | input | 1 | Fast clock (2x), phase-locked to clk_slow |
| rst | input | 1 | Synchronous active-high reset, seen by both domains |
| s_data | input | W | Forward word, slow domain |
| s_valid | input | 1 | Forward word valid, slow domain |
| f_data | output | W | Captured forward word, fast domain |
| f_valid | output | 1 | One-fast-cycle pulse per captured word |
| f_ret_data | input | W | Result word from the fast domain |
| f_ret_valid | input | 1 | Result valid, held at least until the next enabled fast edge |
| s_ret_data | output | W | Returned result, slow domain |
| s_ret_valid | output | 1 | One-slow-cycle pulse per returned result |

## Verification
The bench builds two copies with `W` = 16 and `SETTLE_SLOW` = 2:
- instance u0 uses the toggle style;
- a second instance uses the replica style.

Both copies are fed identical stimulus, which makes the cycle-for-cycle equivalence of the two enable styles directly observable.

The fast clock is offset against the slow clock by +0.9 ns, then −0.9 ns, then 0 ns. This places the nominally shared edges on either side of each other, the exact situation a coincident-edge transfer would get wrong. Each skew setting runs a settle-window probe with valid words present, then a streamed sequence with periodic gaps and returned results.

// File: rtl/bridge_pkg.sv
`timescale 1ns/1ps
package bridge_pkg;
  typedef enum logic {
    PH_REPLICA = 1'b0,
    PH_TOGGLE  = 1'b1
  } phase_style_e;
endpackage

// File: rtl/phase_enable_gen.sv
`timescale 1ns/1ps
module phase_enable_gen #(
  parameter bridge_pkg::phase_style_e STYLE = bridge_pkg::PH_TOGGLE,
  parameter int SETTLE_SLOW = 2
) (
  input  logic clk_slow,
  input  logic clk_fast,
  input  logic rst,
  output logic en
);
  localparam int CW = $clog2(SETTLE_SLOW + 1);
  localparam logic [CW-1:0] SETTLE_V = CW'(SETTLE_SLOW);

  logic ind;
  logic phase_q;
  logic [CW-1:0] cnt;
  logic settled;

  generate
    if (STYLE == bridge_pkg::PH_TOGGLE) begin : g_toggle
      logic tog;
      logic tog_cpy;
      always_ff @(posedge clk_slow) begin
        if (rst) tog <= 1'b0;
        else     tog <= ~tog;
      end
      always_ff @(negedge clk_slow) begin
        if (rst) tog_cpy <= 1'b0;
        else     tog_cpy <= tog;
      end
      assign ind = tog ^ tog_cpy;
    end else begin : g_replica
      assign ind = clk_slow;
    end
  endgenerate

  // retime on the falling fast edge: a quarter slow period from any slow edge
  always_ff @(negedge clk_fast) begin
    if (rst) phase_q <= 1'b0;
    else     phase_q <= ind;
  end

  always_ff @(posedge clk_fast) begin
    if (rst)                        cnt <= '0;
    else if (phase_q && !settled)   cnt <= cnt + 1'b1;
  end

  assign settled = (cnt == SETTLE_V);
  assign en      = phase_q && settled;

  AST_EN_ALTERNATES: assert property (@(posedge clk_fast) disable iff (rst)
    ($past(settled) && settled) |-> (en != $past(en))); // R2
endmodule

// File: rtl/fwd_capture.sv
`timescale 1ns/1ps
module fwd_capture #(
  parameter int W = 16
) (
  input  logic         clk_slow,
  input  logic         clk_fast,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic [W-1:0] out_data,
  output logic         out_valid
);
  logic [W-1:0] hold_d;
  logic         hold_v;

  always_ff @(posedge clk_slow) begin
    if (rst) begin
      hold_d <= '0;
      hold_v <= 1'b0;
    end else begin
      hold_d <= in_data;
      hold_v <= in_valid;
    end
  end

  always_ff @(posedge clk_fast) begin
    if (rst) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= en && hold_v;
      if (en && hold_v) out_data <= hold_d;
    end
  end

  AST_VALID_ON_EN: assert property (@(posedge clk_fast) disable iff (rst)
    out_valid |-> $past(en)); // R3
  AST_DATA_STILL_OFF_EN: assert property (@(posedge clk_fast) disable iff (rst)
    !$past(en) |-> $stable(out_data)); // R4
endmodule

// File: rtl/ret_hold.sv
`timescale 1ns/1ps
module ret_hold #(
  parameter int W = 16
) (
  input  logic         clk_slow,
  input  logic         clk_fast,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic [W-1:0] out_data,
  output logic         out_valid
);
  logic [W-1:0] hold_d;
  logic         hold_v;

  always_ff @(posedge clk_fast) begin
    if (rst) begin
      hold_d <= '0;
      hold_v <= 1'b0;
    end else if (en) begin
      hold_v <= in_valid;
      if (in_valid) hold_d <= in_data;
    end
  end

  always_ff @(posedge clk_slow) begin
    if (rst) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= hold_v;
      if (hold_v) out_data <= hold_d;
    end
  end

  AST_HOLD_STILL_OFF_EN: assert property (@(posedge clk_fast) disable iff (rst)
    !$past(en) |-> $stable({hold_v, hold_d})); // R6
endmodule

// File: rtl/phase_bridge.sv
`timescale 1ns/1ps
module phase_bridge #(
  parameter int W = 16,
  parameter int SETTLE_SLOW = 2,
  parameter bridge_pkg::phase_style_e STYLE = bridge_pkg::PH_TOGGLE
) (
  input  logic         clk_slow,
  input  logic         clk_fast,
  input  logic         rst,
  input  logic [W-1:0] s_data,
  input  logic         s_valid,
  output logic [W-1:0] f_data,
  output logic         f_valid,
  input  logic [W-1:0] f_ret_data,
  input  logic         f_ret_valid,
  output logic [W-1:0] s_ret_data,
  output logic         s_ret_valid
);
  logic en;

  phase_enable_gen #(.STYLE(STYLE), .SETTLE_SLOW(SETTLE_SLOW)) u_en (
    .clk_slow(clk_slow), .clk_fast(clk_fast), .rst(rst), .en(en)
  );

  fwd_capture #(.W(W)) u_fwd (
    .clk_slow(clk_slow), .clk_fast(clk_fast), .rst(rst), .en(en),
    .in_data(s_data), .in_valid(s_valid),
    .out_data(f_data), .out_valid(f_valid)
  );

  ret_hold #(.W(W)) u_ret (
    .clk_slow(clk_slow), .clk_fast(clk_fast), .rst(rst), .en(en),
    .in_data(f_ret_data), .in_valid(f_ret_valid),
    .out_data(s_ret_data), .out_valid(s_ret_valid)
  );

  AST_RESET_FAST_CLEAR: assert property (@(posedge clk_fast)
    $past(rst) |-> (!f_valid && f_data == '0)); // R1
  AST_RESET_SLOW_CLEAR: assert property (@(posedge clk_slow)
    $past(rst) |-> (!s_ret_valid && s_ret_data == '0)); // R1
endmodule

// File: tb/sim_phase_bridge.sv
`timescale 1ns/1ps
module sim_phase_bridge;
  localparam int W = 16;
  localparam int SETTLE = 2;

  logic nom_slow = 1'b0, nom_fast = 1'b0;
  logic clk_slow = 1'b0, clk_fast = 1'b0;
  logic rst = 1'b1;
  real  skew_ns = 0.0;

  logic [W-1:0] s_data = '0;
  logic         s_valid = 1'b0;
  logic [W-1:0] ret_d = '0;
  logic         ret_v = 1'b0;
  int           ret_age = 0;

  logic [W-1:0] f_data0, f_data1, s_ret_data0, s_ret_data1;
  logic         f_valid0, f_valid1, s_ret_valid0, s_ret_valid1;

  int total = 0, bad = 0;
  bit sb_on = 1'b0;
  bit done = 1'b0;
  logic [W-1:0] fwd_q[$];
  logic [W-1:0] ret_q[$];

  // 50 MHz slow clock, 100 MHz fast clock, fast skewed by skew_ns
  initial forever begin
    #5 nom_fast = ~nom_fast;
    if (nom_fast) nom_slow = ~nom_slow;
  end
  always @(nom_slow) clk_slow <= #1.0 nom_slow;
  always @(nom_fast) clk_fast <= #(1.0 + skew_ns) nom_fast;

  phase_bridge #(.W(W), .SETTLE_SLOW(SETTLE), .STYLE(bridge_pkg::PH_TOGGLE)) u0 (
    .clk_slow(clk_slow), .clk_fast(clk_fast), .rst(rst),
    .s_data(s_data), .s_valid(s_valid), .f_data(f_data0), .f_valid(f_valid0),
    .f_ret_data(ret_d), .f_ret_valid(ret_v),
    .s_ret_data(s_ret_data0), .s_ret_valid(s_ret_valid0)
  );

  phase_bridge #(.W(W), .SETTLE_SLOW(SETTLE), .STYLE(bridge_pkg::PH_REPLICA)) u1 (
    .clk_slow(clk_slow), .clk_fast(clk_fast), .rst(rst),
    .s_data(s_data), .s_valid(s_valid), .f_data(f_data1), .f_valid(f_valid1),
    .f_ret_data(ret_d), .f_ret_valid(ret_v),
    .s_ret_data(s_ret_data1), .s_ret_valid(s_ret_valid1)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // fast-domain responder: echoes inverted words, held for one slow period
  always @(negedge clk_fast) begin
    if (rst) begin
      ret_v = 1'b0;
      ret_age = 0;
    end else if (f_valid0) begin
      ret_d = ~f_data0;
      ret_v = 1'b1;
      ret_age = 0;
      if (sb_on) ret_q.push_back(~f_data0);
    end else if (ret_v) begin
      ret_age++;
      if (ret_age >= 2) ret_v = 1'b0;
    end
  end

  // forward monitor and style equivalence
  always @(negedge clk_fast) begin
    if (sb_on) begin
      check({f_valid1, f_data1, s_ret_valid1, s_ret_data1} == {f_valid0, f_data0, s_ret_valid0, s_ret_data0},
            "R7 styles differ", {15'd0, f_valid1, f_data1}, {15'd0, f_valid0, f_data0});
      if (f_valid0) begin
        check(clk_slow == 1'b0, "R4 capture on wrong fast edge", 32'(clk_slow), 32'd0);
        if (fwd_q.size() == 0) begin
          check(1'b0, "R3 R9 extra forward word", 32'(f_data0), 32'd0);
        end else begin
          logic [W-1:0] e;
          e = fwd_q.pop_front();
          check(f_data0 == e, "R3 R9 forward word", 32'(f_data0), 32'(e));
        end
      end
    end
  end

  // return monitor
  always @(negedge clk_slow) begin
    if (sb_on && s_ret_valid0) begin
      if (ret_q.size() == 0) begin
        check(1'b0, "R5 R6 extra returned word", 32'(s_ret_data0), 32'd0);
      end else begin
        logic [W-1:0] e;
        e = ret_q.pop_front();
        check(s_ret_data0 == e, "R5 R6 R9 returned word", 32'(s_ret_data0), 32'(e));
      end
    end
  end

  task automatic run_phase(input real sk, input int base);
    skew_ns = sk;
    rst = 1'b1;
    s_valid = 1'b0;
    s_data = '0;
    repeat (4) @(negedge clk_slow);
    @(negedge clk_fast);
    check({f_valid0, f_data0, s_ret_valid0, s_ret_data0} == '0, "R1 reset state u0",
          {15'd0, f_valid0, f_data0}, 32'd0);
    check({f_valid1, f_data1, s_ret_valid1, s_ret_data1} == '0, "R1 reset state u1",
          {15'd0, s_ret_valid1, s_ret_data1}, 32'd0);
    // settle window probe: valid words present, no capture allowed
    rst = 1'b0;
    s_valid = 1'b1;
    s_data = W'(base + 16'h0a5);
    for (int i = 0; i < 2 * SETTLE; i++) begin
      @(negedge clk_fast);
      check(!f_valid0 && !f_valid1, "R8 capture inside settle window",
            {30'd0, f_valid1, f_valid0}, 32'd0);
    end
    rst = 1'b1;
    s_valid = 1'b0;
    repeat (3) @(negedge clk_slow);
    @(negedge clk_fast);
    rst = 1'b0;
    repeat (SETTLE + 3) @(negedge clk_slow);
    sb_on = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_slow);
      s_valid = (i % 5 != 3);
      s_data = W'(base + i * 37 + 1);
      if (s_valid) fwd_q.push_back(s_data);
    end
    @(negedge clk_slow);
    s_valid = 1'b0;
    repeat (8) @(negedge clk_slow);
    sb_on = 1'b0;
    check(fwd_q.size() == 0, "R3 forward word never captured", 32'(fwd_q.size()), 32'd0);
    check(ret_q.size() == 0, "R5 returned word lost", 32'(ret_q.size()), 32'd0);
    fwd_q.delete();
    ret_q.delete();
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    run_phase(0.9, 16'h1000);
    run_phase(-0.9, 16'h4000);
    run_phase(0.0, 16'h8000);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule